// File: doc/BRIEF.md
# Logical Device Resource Register Bank

This block holds the resource settings of eight logical devices inside a multi-function I/O controller. Software reaches it through three I/O ports. A write to the index port chooses a register. A write to the data port stores a value into that register. A read from the readback port returns the contents of that register. The block takes part in bus cycles only while the configuration-enable input is high. When that input is low, every access is ignored.

A selector register picks one of the eight logical devices. The enable, base-address (high and low byte), interrupt-line and DMA-channel registers are kept separately for each device, and an access reaches only the copy of the device that is currently selected. Each device's active bit, 16-bit base address and interrupt line are driven out in parallel, so the surrounding address decoders and interrupt routing can use them directly. When an enable register is written with a new value, the block raises a one-cycle remap pulse for that device.

Top module: `ldev_cfg_bank`

## Requirements
- R1: While `cfg_en` is low, no write changes any register. A read strobe sent to the readback port loads 0xFF into `rd_data` on the next clock edge.
- R2: With `cfg_en` high, a write to address 0x0279 loads the register index, and a write to address 0x0A79 stores data into the indexed register. A read strobe at 0x03E3 loads `rd_data` with the indexed value on the next edge. A write strobe at any other address, including 0x03E3, has no effect.
- R3: Index 0x07 is the device selector. A write stores the low 3 bits of the data, and a read returns the selector value with its upper bits zero.
- R4: Indices 0x30 (enable), 0x60 (base high byte), 0x61 (base low byte), 0x70 (interrupt) and 0x74 (DMA) are kept separately for each device. Each holds all 8 written bits, and an access reaches only the copy of the selected device.
- R5: A data write to any index other than those in R3 and R4 changes nothing. A read of such an index returns 0xFF.
- R6: After reset, devices 0 to 3 have an enable value of 0x01. Device 0 has base 0x03F0, interrupt 6 and DMA 2. Device 1 has base 0x03F8 and interrupt 4. Device 2 has base 0x02F8 and interrupt 3. Device 3 has base 0x0378 and interrupt 7. Every other field of every device is zero.
- R7: `dev_active[d]` equals bit 0 of device d's enable register. The other bits of that register have no effect on it.
- R8: `dev_base[16*d +: 16]` equals {high byte, low byte} of device d.
- R9: `dev_irq[4*d +: 4]` is the low 4 bits of device d's interrupt register. `dev_irq_vld[d]` is 1 for every device except device 3 (the parallel port). For device 3 it is 1 only when the register value is 15 or less.
- R10: A data write to index 0x30 whose value differs from the stored one sets `dev_remap[d]` high for exactly the following cycle. Rewriting the same value gives no pulse. At most one remap bit is high in any cycle.
- R11: Reset clears the index to 0x00 and the selector to 0, and sets `rd_data` to 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration access enable |
| bus_addr | input | 16 | I/O address of the access |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 8 | Registered readback data |
| dev_active | output | 8 | Active bit of each device |
| dev_base | output | 128 | Base address of each device, 16 bits per device |
| dev_irq | output | 32 | Interrupt line of each device, 4 bits per device |
| dev_irq_vld | output | 8 | Interrupt line is valid, one bit per device |
| dev_remap | output | 8 | One-cycle pulse after an enable value changes |

## Verification
The assertions assume that reset is high from time zero until the first clock edges have passed. They also assume that `bus_wr` and `bus_rd` are single-cycle strobes with a stable address during that cycle. The bench drives every strobe as one cycle long and launches it at a falling edge, and it holds reset over several edges at the start. Enable-register writes are always separated by idle cycles, so each remap pulse can be seen on its own before the next access.

// File: rtl/ldev_pkg.sv
package ldev_pkg;

  typedef enum logic [2:0] {
    FLD_NONE, FLD_SEL, FLD_EN, FLD_BHI, FLD_BLO, FLD_IRQ, FLD_DMA
  } fld_e;

  // index -> field class
  function automatic fld_e idx_to_fld(input logic [7:0] idx);
    case (idx)
      8'h07:   return FLD_SEL;
      8'h30:   return FLD_EN;
      8'h60:   return FLD_BHI;
      8'h61:   return FLD_BLO;
      8'h70:   return FLD_IRQ;
      8'h74:   return FLD_DMA;
      default: return FLD_NONE;
    endcase
  endfunction

  // per-device power-up values
  function automatic logic [7:0] rst_en(input int d);
    return (d < 4) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic [15:0] rst_base(input int d);
    case (d)
      0:       return 16'h03F0;
      1:       return 16'h03F8;
      2:       return 16'h02F8;
      3:       return 16'h0378;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [7:0] rst_irq(input int d);
    case (d)
      0:       return 8'd6;
      1:       return 8'd4;
      2:       return 8'd3;
      3:       return 8'd7;
      default: return 8'd0;
    endcase
  endfunction

  function automatic logic [7:0] rst_dma(input int d);
    return (d == 0) ? 8'd2 : 8'd0;
  endfunction

endpackage

// File: rtl/ldev_port_decode.sv
module ldev_port_decode #(
  parameter int          AW       = 16,
  parameter logic [15:0] IDX_PORT = 16'h0279,
  parameter logic [15:0] DAT_PORT = 16'h0A79,
  parameter logic [15:0] RD_PORT  = 16'h03E3
) (
  input  logic          cfg_en,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  output logic          idx_wr,
  output logic          dat_wr,
  output logic          dat_rd,
  output logic          rd_off
);
  always_comb begin
    idx_wr = cfg_en && wr && (addr == AW'(IDX_PORT));
    dat_wr = cfg_en && wr && (addr == AW'(DAT_PORT));
    dat_rd = cfg_en && rd && (addr == AW'(RD_PORT));
    rd_off = !cfg_en && rd && (addr == AW'(RD_PORT));
  end
endmodule

// File: rtl/ldev_slot.sv
module ldev_slot
  import ldev_pkg::*;
#(
  parameter int            DW          = 8,
  parameter int            IRQW        = 4,
  parameter logic [7:0]    RST_EN      = 8'h00,
  parameter logic [15:0]   RST_BASE    = 16'h0000,
  parameter logic [7:0]    RST_IRQ     = 8'h00,
  parameter logic [7:0]    RST_DMA     = 8'h00,
  parameter bit            RANGE_CHECK = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  fld_e            fld,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   en_q,
  output logic [DW-1:0]   bhi_q,
  output logic [DW-1:0]   blo_q,
  output logic [DW-1:0]   irq_q,
  output logic [DW-1:0]   dma_q,
  output logic            remap,
  output logic [IRQW-1:0] irq_num,
  output logic            irq_vld
);
  localparam logic [DW-1:0] IRQ_MAX = DW'({IRQW{1'b1}});

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= DW'(RST_EN);
      bhi_q <= DW'(RST_BASE[15:8]);
      blo_q <= DW'(RST_BASE[7:0]);
      irq_q <= DW'(RST_IRQ);
      dma_q <= DW'(RST_DMA);
      remap <= 1'b0;
    end else begin
      remap <= 1'b0;
      if (we) begin
        case (fld)
          FLD_EN: begin
            en_q  <= wdata;
            remap <= (wdata != en_q);
          end
          FLD_BHI: bhi_q <= wdata;
          FLD_BLO: blo_q <= wdata;
          FLD_IRQ: irq_q <= wdata;
          FLD_DMA: dma_q <= wdata;
          default: ;
        endcase
      end
    end
  end

  assign irq_num = irq_q[IRQW-1:0];

  generate
    if (RANGE_CHECK) begin : g_lim
      assign irq_vld = (irq_q <= IRQ_MAX);
    end else begin : g_nolim
      assign irq_vld = 1'b1;
    end
  endgenerate

  // R10: a pulse only follows an enable write that altered the value
  p_remap_change_r10: assert property (@(posedge clk) disable iff (rst)
    remap |-> (en_q != $past(en_q)));
  p_remap_cause_r10: assert property (@(posedge clk) disable iff (rst)
    remap |-> $past(we && fld == FLD_EN));
endmodule

// File: rtl/ldev_cfg_bank.sv
module ldev_cfg_bank
  import ldev_pkg::*;
#(
  parameter int NDEV    = 8,
  parameter int AW      = 16,
  parameter int DW      = 8,
  parameter int BW      = 16,
  parameter int IRQW    = 4,
  parameter int PAR_DEV = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DW-1:0]     rd_data,
  output logic [NDEV-1:0]   dev_active,
  output logic [NDEV*BW-1:0]   dev_base,
  output logic [NDEV*IRQW-1:0] dev_irq,
  output logic [NDEV-1:0]   dev_irq_vld,
  output logic [NDEV-1:0]   dev_remap
);
  localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic            idx_wr, dat_wr, dat_rd, rd_off;
  logic [DW-1:0]   idx_q;
  logic [SELW-1:0] sel_q;
  fld_e            fld;
  logic [DW-1:0]   rd_mux;

  logic [DW-1:0] en_a  [NDEV];
  logic [DW-1:0] bhi_a [NDEV];
  logic [DW-1:0] blo_a [NDEV];
  logic [DW-1:0] irq_a [NDEV];
  logic [DW-1:0] dma_a [NDEV];

  ldev_port_decode #(.AW(AW)) u_dec (
    .cfg_en (cfg_en),
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .idx_wr (idx_wr),
    .dat_wr (dat_wr),
    .dat_rd (dat_rd),
    .rd_off (rd_off)
  );

  assign fld = idx_to_fld(8'(idx_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      sel_q <= '0;
    end else begin
      if (idx_wr) idx_q <= bus_wdata;
      if (dat_wr && fld == FLD_SEL) sel_q <= bus_wdata[SELW-1:0];
    end
  end

  genvar d;
  generate
    for (d = 0; d < NDEV; d++) begin : g_dev
      ldev_slot #(
        .DW          (DW),
        .IRQW        (IRQW),
        .RST_EN      (rst_en(d)),
        .RST_BASE    (rst_base(d)),
        .RST_IRQ     (rst_irq(d)),
        .RST_DMA     (rst_dma(d)),
        .RANGE_CHECK (d == PAR_DEV)
      ) u_slot (
        .clk     (clk),
        .rst     (rst),
        .we      (dat_wr && (sel_q == SELW'(d))),
        .fld     (fld),
        .wdata   (bus_wdata),
        .en_q    (en_a[d]),
        .bhi_q   (bhi_a[d]),
        .blo_q   (blo_a[d]),
        .irq_q   (irq_a[d]),
        .dma_q   (dma_a[d]),
        .remap   (dev_remap[d]),
        .irq_num (dev_irq[d*IRQW +: IRQW]),
        .irq_vld (dev_irq_vld[d])
      );
      assign dev_active[d]         = en_a[d][0];
      assign dev_base[d*BW +: BW]  = BW'({bhi_a[d], blo_a[d]});
    end
  endgenerate

  always_comb begin
    case (fld)
      FLD_SEL: rd_mux = DW'(sel_q);
      FLD_EN:  rd_mux = en_a[sel_q];
      FLD_BHI: rd_mux = bhi_a[sel_q];
      FLD_BLO: rd_mux = blo_a[sel_q];
      FLD_IRQ: rd_mux = irq_a[sel_q];
      FLD_DMA: rd_mux = dma_a[sel_q];
      default: rd_mux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '1;
    else if (dat_rd) rd_data <= rd_mux;
    else if (rd_off) rd_data <= '1;
  end

  // R1: disabled accesses leave index and selector untouched
  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> ($stable(idx_q) && $stable(sel_q)));
  // R1: a read while disabled returns all ones
  p_rd_off_ff_r1: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !cfg_en && bus_addr == AW'(16'h03E3)) |=> (rd_data == '1));
  // R10: never more than one remap pulse at a time
  p_remap_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_remap));
  // R9: parallel port interrupt beyond 15 is reported invalid
  p_par_irq_none_r9: assert property (@(posedge clk) disable iff (rst)
    (irq_a[PAR_DEV] > DW'(15)) |-> !dev_irq_vld[PAR_DEV]);
endmodule

// File: tb/sim_ldev_cfg_bank.sv
module sim_ldev_cfg_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  rd_data;
  logic [7:0]  dev_active;
  logic [127:0] dev_base;
  logic [31:0] dev_irq;
  logic [7:0]  dev_irq_vld;
  logic [7:0]  dev_remap;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ldev_cfg_bank u0 (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .rd_data(rd_data), .dev_active(dev_active), .dev_base(dev_base),
    .dev_irq(dev_irq), .dev_irq_vld(dev_irq_vld), .dev_remap(dev_remap)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk);
    bus_addr = 16'h03E3; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic sel_idx(input logic [7:0] dv, input logic [7:0] idx);
    wr(16'h0279, 8'h07); wr(16'h0A79, dv); wr(16'h0279, idx);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R11 rd_data reset", rd_data, 8'hFF);
    chk("R6 active", dev_active, 8'h0F);
    chk("R6 base0", dev_base[0 +: 16], 16'h03F0);
    chk("R6 base1", dev_base[16 +: 16], 16'h03F8);
    chk("R6 base2", dev_base[32 +: 16], 16'h02F8);
    chk("R6 base3", dev_base[48 +: 16], 16'h0378);
    chk("R6 base5", dev_base[80 +: 16], 16'h0000);
    chk("R6 irqs", dev_irq[15:0], 16'h7346);
    chk("R9 vld reset", dev_irq_vld, 8'hFF);
    chk("R10 no remap", dev_remap, 8'h00);
    rd(v); chk("R11 index 0 reads FF", v, 8'hFF);
    wr(16'h0279, 8'h07); rd(v); chk("R11 selector 0", v, 8'h00);
    wr(16'h0279, 8'h74); rd(v); chk("R6 dma dev0", v, 8'h02);
    sel_idx(8'h03, 8'h70); rd(v); chk("R6 irq dev3 readback", v, 8'h07);
    sel_idx(8'h05, 8'h30); rd(v); chk("R6 dev5 enable zero", v, 8'h00);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    sel_idx(8'h00, 8'h07);
    cfg_en = 1'b0;
    wr(16'h0279, 8'h30); wr(16'h0A79, 8'h00);
    chk("R1 active unchanged", dev_active, 8'h0F);
    chk("R1 no remap", dev_remap, 8'h00);
    rd(v); chk("R1 read off", v, 8'hFF);
    cfg_en = 1'b1;
    rd(v); chk("R1 index kept", v, 8'h00);
  endtask

  task automatic t_bank;
    logic [7:0] v;
    sel_idx(8'h05, 8'h60); wr(16'h0A79, 8'h12);
    wr(16'h0279, 8'h61); wr(16'h0A79, 8'h34);
    wr(16'h0279, 8'h70); wr(16'h0A79, 8'h09);
    wr(16'h0279, 8'h74); wr(16'h0A79, 8'hA1);
    chk("R8 base5", dev_base[80 +: 16], 16'h1234);
    chk("R9 irq5", dev_irq[20 +: 4], 4'h9);
    rd(v); chk("R4 dma5 full byte", v, 8'hA1);
    wr(16'h0279, 8'h30); wr(16'h0A79, 8'h03);
    chk("R10 pulse dev5", dev_remap, 8'h20);
    chk("R7 active dev5", dev_active, 8'h2F);
    @(negedge clk); chk("R10 pulse one cycle", dev_remap, 8'h00);
    sel_idx(8'h01, 8'h60); rd(v); chk("R4 dev1 untouched", v, 8'h03);
    chk("R4 base1 untouched", dev_base[16 +: 16], 16'h03F8);
  endtask

  task automatic t_remap;
    sel_idx(8'h01, 8'h30);
    wr(16'h0A79, 8'h01);
    chk("R10 same value no pulse", dev_remap, 8'h00);
    wr(16'h0A79, 8'h00);
    chk("R10 change pulse", dev_remap, 8'h02);
    chk("R7 dev1 off", dev_active, 8'h2D);
    @(negedge clk);
    wr(16'h0A79, 8'h02);
    chk("R10 pulse on 00->02", dev_remap, 8'h02);
    chk("R7 bit1 ignored", dev_active, 8'h2D);
  endtask

  task automatic t_other;
    logic [7:0] v;
    wr(16'h0279, 8'h31); wr(16'h0A79, 8'h55);
    rd(v); chk("R5 unknown index reads FF", v, 8'hFF);
    chk("R5 active unchanged", dev_active, 8'h2D);
    wr(16'h0279, 8'h07); wr(16'h0A79, 8'hFB);
    rd(v); chk("R3 low bits only", v, 8'h03);
    wr(16'h0279, 8'h70); wr(16'h03E3, 8'h0C);
    chk("R2 write to read port ignored", dev_irq[12 +: 4], 4'h7);
    wr(16'h0A79, 8'h10);
    chk("R9 par irq 16 none", dev_irq_vld[3], 1'b0);
    wr(16'h0A79, 8'h0F);
    chk("R9 par irq 15 valid", dev_irq_vld[3], 1'b1);
    chk("R9 par irq num", dev_irq[12 +: 4], 4'hF);
    sel_idx(8'h02, 8'h70); wr(16'h0A79, 8'h20);
    chk("R9 non-par always valid", dev_irq_vld[2], 1'b1);
    chk("R9 non-par low bits", dev_irq[8 +: 4], 4'h0);
    rd(v); chk("R2 readback irq2", v, 8'h20);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cfg_en = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_bank();
    t_remap();
    t_other();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule